// File: doc/BRIEF.md
# Slew-Limited Oscillator Frequency Regulator

This block owns the frequency word that sets a half-bridge oscillator. It holds the word between a bottom limit and a start limit. It nudges the word up or down by a bounded step each time a sampling strobe arrives, so the frequency never jumps. The input `start_i` opens preheat and places the word at the start limit. After that, comparator results taken at specific points of the low-side conduction period steer the word.

The block has two sensing modes. In shunt-regulation mode it samples the sense comparator when low-side conduction ends. A sense level above the threshold lowers the frequency, and one below the threshold raises it. In protection mode it samples at low-side turn-on. A capacitive-mode flag raises the frequency. Without that flag the word settles toward a floor, which is the larger of the bottom limit and an externally averaged feed-forward word. During the ignition phase the downward step shrinks to a much smaller value. Upward steps stay the same size in every phase.

A bottom-reached flag reports when the word sits on the floor that is active at that moment.

Top module: `freq_slew_reg`

## Requirements
- R1: After reset `freq_o` equals F_START, and at every cycle it satisfies F_BOTTOM <= `freq_o` <= F_START.
- R2: `start_i` high at a clock edge makes `freq_o` equal F_START on the next cycle. It takes priority over any strobe in the same cycle.
- R3: Shunt mode (`mode_i`=0), sampled on `strobe_end_i`: `cmp_i`=1 (sense above threshold) lowers the word by the down step, stopping at F_BOTTOM. `cmp_i`=0 raises it by STEP_UP, stopping at F_START. In this mode `strobe_on_i` has no effect.
- R4: Protection mode (`mode_i`=1), sampled on `strobe_on_i`: `cmp_i`=1 (capacitive operation) raises the word by STEP_UP, stopping at F_START. In this mode `strobe_end_i` has no effect.
- R5: In protection mode with `cmp_i`=0, the word moves toward floor = min(F_START, max(F_BOTTOM, `ff_floor_i`)). Above the floor it falls by the down step and stops at the floor. Below the floor it rises by STEP_UP and stops at the floor.
- R6: While `ign_i`=1 the down step is STEP_IGN. Otherwise it is STEP_DN. The up step is STEP_UP in both cases.
- R7: In a cycle with neither `start_i` nor the strobe of the current mode, `freq_o` holds its value.
- R8: `bottom_o` is 1 exactly when `freq_o` equals the active floor. The active floor is F_BOTTOM in shunt mode and the R5 floor in protection mode, evaluated from the present inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Preheat begin: reload start limit |
| mode_i | input | 1 | 0 shunt regulation, 1 capacitive protection |
| ign_i | input | 1 | Ignition phase: slow downward slew |
| strobe_end_i | input | 1 | End of low-side conduction |
| strobe_on_i | input | 1 | Start of low-side conduction |
| cmp_i | input | 1 | Comparator result for the active mode |
| ff_floor_i | input | FW | Averaged feed-forward frequency word |
| freq_o | output | FW | Oscillator frequency word |
| bottom_o | output | 1 | Word sits on the active floor |

## Verification
Two cases can fall in the same cycle. In the first, a preheat restart and a sampling strobe coincide. In the second, both strobes arrive together and only the strobe of the current mode may act. The bench drives `start_i` together with a down-steering strobe and expects the start limit on the following cycle. It also raises both strobes in each mode and expects exactly one step whose direction the active mode's rule decides. A long pseudo-random sweep produces these collisions again, mixed with moves of the feed-forward floor, and compares every cycle against a reference model of the word and the flag.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    typedef enum logic {
        SENSE_SHUNT = 1'b0,
        SENSE_PROT  = 1'b1
    } sense_mode_e;

    typedef struct packed {
        logic act;   // a qualifying sample was taken this cycle
        logic up;    // 1 raise frequency, 0 settle toward floor
    } slew_cmd_t;
endpackage

// File: rtl/fsr_floor.sv
module fsr_floor #(
    parameter int FW       = 12,
    parameter int F_START  = 1080,
    parameter int F_BOTTOM = 430
) (
    input  logic          mode_i,
    input  logic [FW-1:0] ff_i,
    output logic [FW-1:0] floor_o
);
    localparam logic [FW-1:0] START_W  = FW'(F_START);
    localparam logic [FW-1:0] BOTTOM_W = FW'(F_BOTTOM);

    logic [FW-1:0] raised;

    always_comb begin
        raised = (ff_i > BOTTOM_W) ? ff_i : BOTTOM_W;
        if (raised > START_W) begin
            raised = START_W;
        end
        floor_o = (fsr_pkg::sense_mode_e'(mode_i) == fsr_pkg::SENSE_PROT) ? raised : BOTTOM_W;
    end
endmodule

// File: rtl/fsr_decide.sv
module fsr_decide (
    input  logic                mode_i,
    input  logic                strobe_end_i,
    input  logic                strobe_on_i,
    input  logic                cmp_i,
    output fsr_pkg::slew_cmd_t  cmd_o
);
    import fsr_pkg::*;

    always_comb begin
        cmd_o = '0;
        if (sense_mode_e'(mode_i) == SENSE_SHUNT) begin
            cmd_o.act = strobe_end_i;
            cmd_o.up  = ~cmp_i;          // sense above threshold -> lower
        end else begin
            cmd_o.act = strobe_on_i;
            cmd_o.up  = cmp_i;           // capacitive detected -> raise
        end
    end
endmodule

// File: rtl/fsr_slew.sv
module fsr_slew #(
    parameter int FW       = 12,
    parameter int F_START  = 1080,
    parameter int STEP_UP  = 25,
    parameter int STEP_DN  = 10,
    parameter int STEP_IGN = 1
) (
    input  logic               [FW-1:0] freq_i,
    input  logic               [FW-1:0] floor_i,
    input  fsr_pkg::slew_cmd_t          cmd_i,
    input  logic                        ign_i,
    output logic               [FW-1:0] freq_o
);
    localparam int EW = FW + 1;
    localparam logic [EW-1:0] START_E = EW'(F_START);
    localparam logic [EW-1:0] UP_E    = EW'(STEP_UP);

    logic [EW-1:0] f_e;
    logic [EW-1:0] fl_e;
    logic [EW-1:0] up_sum;
    logic [EW-1:0] dn_e;

    generate
        if (STEP_IGN == STEP_DN) begin : g_one_rate
            assign dn_e = EW'(STEP_DN);
        end else begin : g_two_rate
            assign dn_e = ign_i ? EW'(STEP_IGN) : EW'(STEP_DN);
        end
    endgenerate

    always_comb begin
        f_e    = {1'b0, freq_i};
        fl_e   = {1'b0, floor_i};
        up_sum = f_e + UP_E;
        freq_o = freq_i;
        if (cmd_i.act) begin
            if (cmd_i.up) begin
                freq_o = (up_sum > START_E) ? START_E[FW-1:0] : up_sum[FW-1:0];
            end else if (f_e > fl_e) begin
                freq_o = ((f_e - fl_e) > dn_e) ? FW'(f_e - dn_e) : floor_i;
            end else if (f_e < fl_e) begin
                freq_o = (up_sum > fl_e) ? floor_i : up_sum[FW-1:0];
            end
        end
    end
endmodule

// File: rtl/freq_slew_reg.sv
module freq_slew_reg #(
    parameter int FW       = 12,
    parameter int F_START  = 1080,
    parameter int F_BOTTOM = 430,
    parameter int STEP_UP  = 25,
    parameter int STEP_DN  = 10,
    parameter int STEP_IGN = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_i,
    input  logic          ign_i,
    input  logic          strobe_end_i,
    input  logic          strobe_on_i,
    input  logic          cmp_i,
    input  logic [FW-1:0] ff_floor_i,
    output logic [FW-1:0] freq_o,
    output logic          bottom_o
);
    localparam logic [FW-1:0] START_W = FW'(F_START);

    typedef struct packed {
        logic [FW-1:0] freq;
    } reg_state_t;

    reg_state_t         st_d, st_q;
    logic [FW-1:0]      floor_w;
    logic [FW-1:0]      slewed_w;
    fsr_pkg::slew_cmd_t cmd_w;

    fsr_floor #(.FW(FW), .F_START(F_START), .F_BOTTOM(F_BOTTOM)) u_floor (
        .mode_i  (mode_i),
        .ff_i    (ff_floor_i),
        .floor_o (floor_w)
    );

    fsr_decide u_decide (
        .mode_i       (mode_i),
        .strobe_end_i (strobe_end_i),
        .strobe_on_i  (strobe_on_i),
        .cmp_i        (cmp_i),
        .cmd_o        (cmd_w)
    );

    fsr_slew #(.FW(FW), .F_START(F_START), .STEP_UP(STEP_UP),
               .STEP_DN(STEP_DN), .STEP_IGN(STEP_IGN)) u_slew (
        .freq_i  (st_q.freq),
        .floor_i (floor_w),
        .cmd_i   (cmd_w),
        .ign_i   (ign_i),
        .freq_o  (slewed_w)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.freq = START_W;
        end else begin
            st_d.freq = slewed_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.freq <= START_W;
        end else begin
            st_q <= st_d;
        end
    end

    assign freq_o   = st_q.freq;
    assign bottom_o = (st_q.freq == floor_w);
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
    parameter int FW       = 12,
    parameter int F_START  = 1080,
    parameter int F_BOTTOM = 430,
    parameter int STEP_UP  = 25,
    parameter int STEP_DN  = 10,
    parameter int STEP_IGN = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          mode_i,
    input logic          ign_i,
    input logic          strobe_end_i,
    input logic          strobe_on_i,
    input logic          cmp_i,
    input logic [FW-1:0] ff_floor_i,
    input logic [FW-1:0] freq_o,
    input logic          bottom_o
);
    assert_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(freq_o) >= F_BOTTOM) && (int'(freq_o) <= F_START));

    assert_start_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (int'(freq_o) == F_START));

    assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (int'(freq_o) <= int'($past(freq_o)) + STEP_UP) &&
                     (int'(freq_o) + STEP_DN >= int'($past(freq_o))));

    assert_ign_slow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && ign_i) |=> (int'(freq_o) + STEP_IGN >= int'($past(freq_o))));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !strobe_end_i && !strobe_on_i) |=> $stable(freq_o));

    assert_bottom_shunt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && bottom_o) |-> (int'(freq_o) == F_BOTTOM));

    assert_capmode_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && mode_i && strobe_on_i && cmp_i) |=> (freq_o >= $past(freq_o)));
endmodule

bind freq_slew_reg fsr_checker #(
    .FW(FW), .F_START(F_START), .F_BOTTOM(F_BOTTOM),
    .STEP_UP(STEP_UP), .STEP_DN(STEP_DN), .STEP_IGN(STEP_IGN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .mode_i       (mode_i),
    .ign_i        (ign_i),
    .strobe_end_i (strobe_end_i),
    .strobe_on_i  (strobe_on_i),
    .cmp_i        (cmp_i),
    .ff_floor_i   (ff_floor_i),
    .freq_o       (freq_o),
    .bottom_o     (bottom_o)
);

// File: tb/freq_slew_reg_test.sv
`timescale 1ns/1ps
module freq_slew_reg_test;
    localparam int FW = 12, FS = 1080, FB = 430, SU = 25, SD = 10, SI = 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 0, mode_i = 0, ign_i = 0, se_i = 0, so_i = 0, cmp_i = 0;
    logic [FW-1:0] ff_i = '0;
    logic [FW-1:0] freq_o;
    logic bottom_o;

    int checks = 0, errors = 0, exp_f = FS;
    bit done = 0;

    always #2.5 clk = ~clk;

    freq_slew_reg #(.FW(FW), .F_START(FS), .F_BOTTOM(FB), .STEP_UP(SU),
                    .STEP_DN(SD), .STEP_IGN(SI)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .ign_i(ign_i),
        .strobe_end_i(se_i), .strobe_on_i(so_i), .cmp_i(cmp_i), .ff_floor_i(ff_i),
        .freq_o(freq_o), .bottom_o(bottom_o));

    function automatic int floor_of(bit md, int ff);
        int r;
        if (!md) return FB;
        r = (ff > FB) ? ff : FB;
        return (r > FS) ? FS : r;
    endfunction

    function automatic int model(int f, bit st, bit md, bit ig, bit se, bit so, bit c, int ff);
        int fl = floor_of(md, ff);
        int dn = ig ? SI : SD;
        bit act = md ? so : se;
        bit up  = md ? c : !c;
        if (st) return FS;
        if (!act) return f;
        if (up) return (f + SU > FS) ? FS : f + SU;
        if (f > fl) return (f - dn < fl) ? fl : f - dn;
        if (f < fl) return (f + SU > fl) ? fl : f + SU;
        return f;
    endfunction

    function automatic string tag_of(bit st, bit md, bit ig, bit se, bit so, bit c);
        if (st) return "R2";
        if (!md && se) return "R3";
        if (md && so && c) return "R4";
        if (md && so && ig) return "R6";
        if (md && so) return "R5";
        return "R7";
    endfunction

    task automatic chk(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // drive at negedge, one rising edge, check at next negedge
    task automatic cyc(bit st, bit md, bit ig, bit se, bit so, bit c, int ff);
        start_i = st; mode_i = md; ign_i = ig; se_i = se; so_i = so; cmp_i = c;
        ff_i = FW'(ff);
        exp_f = model(exp_f, st, md, ig, se, so, c, ff);
        @(negedge clk);
        chk(tag_of(st, md, ig, se, so, c), int'(freq_o), exp_f);
        chk("R8", int'(bottom_o), int'(exp_f == floor_of(md, ff)));
        if (int'(freq_o) < FB || int'(freq_o) > FS) chk("R1", int'(freq_o), FB);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf = 16'hACE1;
        repeat (3) @(negedge clk);
        chk("R1", int'(freq_o), FS);                  // reset value
        rst_n = 1;
        // R3: shunt descent to bottom, clamp, bottom flag
        for (int i = 0; i < 70; i++) cyc(0, 0, 0, 1, 0, 1, 0);
        chk("R3", int'(freq_o), FB);
        chk("R8", int'(bottom_o), 1);
        // R3: strobe_on ignored in shunt mode
        cyc(0, 0, 0, 0, 1, 0, 0);
        chk("R3", int'(freq_o), FB);
        // R3: rise to start clamp
        for (int i = 0; i < 30; i++) cyc(0, 0, 0, 1, 0, 0, 0);
        chk("R3", int'(freq_o), FS);
        // R5: protection settles on ff floor 700
        for (int i = 0; i < 50; i++) cyc(0, 1, 0, 0, 1, 0, 700);
        chk("R5", int'(freq_o), 700);
        chk("R8", int'(bottom_o), 1);
        // R4: strobe_end ignored in protection mode
        cyc(0, 1, 0, 1, 0, 1, 700);
        chk("R4", int'(freq_o), 700);
        // R5: floor raised to 900, word rises to it
        for (int i = 0; i < 12; i++) cyc(0, 1, 0, 0, 1, 0, 900);
        chk("R5", int'(freq_o), 900);
        // R5: ff beyond start limit clamps floor to start
        for (int i = 0; i < 12; i++) cyc(0, 1, 0, 0, 1, 0, 4000);
        chk("R5", int'(freq_o), FS);
        // R6: ignition slow descent
        for (int i = 0; i < 20; i++) cyc(0, 1, 1, 0, 1, 0, 0);
        chk("R6", int'(freq_o), FS - 20);
        // R4: capacitive rise
        cyc(0, 1, 1, 0, 1, 1, 0);
        chk("R4", int'(freq_o), FS - 20 + SU > FS ? FS : FS - 20 + SU);
        // coincidence: start with a down strobe, and both strobes together
        for (int i = 0; i < 10; i++) cyc(0, 0, 0, 1, 1, 1, 0);
        cyc(1, 0, 0, 1, 1, 1, 0);
        chk("R2", int'(freq_o), FS);
        cyc(0, 1, 0, 1, 1, 0, 500);
        chk("R5", int'(freq_o), FS - SD);
        // near-exhaustive pseudo-random sweep
        for (int i = 0; i < 6000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cyc(lf[15:8] == 8'h00, lf[12] ^ (i >= 3000), lf[3] & lf[4],
                lf[1], lf[2], lf[5] & lf[6], 300 + 100 * int'(lf[10:8]) + (i / 1000) * 50);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule